// File: doc/BRIEF.md
# Character LCD Parallel Write Engine

This block puts host bytes onto the parallel bus of a character display module. The host offers one byte and a register-select flag per request over a valid/ready handshake. The engine drives the select line, holds the read/write line low, places the byte on the data lines and pulses the enable line. The display latches the bus on the falling edge of that pulse. Every bus interval is a parameter given in nanoseconds. Each is turned into whole clock cycles, rounded up, from the clock frequency parameter.

A static input picks the bus width for each request and is sampled when the request is accepted. In full-width mode the byte goes out in one strobe. In half-width mode only the upper four data lines carry data: the high nibble is strobed first, then the low nibble. The lower four lines stay at zero. The engine does not read the busy flag. After the last strobe it waits a fixed execution time and only then takes the next request. The wait is long for the clear and home instructions and short for everything else.

Top module: `lcd_write_engine`

## Requirements
- R1: After reset, ready is 1, enable is 0, read/write is 0, register select is 0 and all data lines are 0.
- R2: Ready falls on the clock edge that accepts a request. It stays 0 until the execution wait has run out, which is exactly EXEC cycles after the enable falls for the last time.
- R3: Register select carries the request's flag through the whole transfer (0 = instruction, 1 = data), and read/write is 0 at all times.
- R4: With the width input at 1 (full width), a request produces one enable pulse, and all eight data lines carry the byte during it.
- R5: With the width input at 0 (half width), a request produces two enable pulses. The first carries byte bits 7..4 on data lines 7..4, the second carries bits 3..0 there, and data lines 3..0 read 0 during both.
- R6: Each enable pulse stays high for ceil(230 ns / clock period) cycles (12 cycles at 50 MHz).
- R7: Select and data settle on the accepting edge, which is ceil(40 ns / clock period) cycles before the enable rises. They stay constant while the enable is high and are still unchanged one cycle after it falls.
- R8: In half-width mode the two rising edges of the enable are at least ceil(500 ns / clock period) cycles apart (25 cycles at 50 MHz).
- R9: The execution wait uses the long time only when select is 0 and the byte is 0x01, 0x02 or 0x03. Every other combination, including select 1 with byte 0x01 and select 0 with bytes 0x00 or 0x04, uses the short time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host offers a byte |
| req_ready | output | 1 | Engine can take a byte |
| req_rs | input | 1 | Register select for the byte: 0 instruction, 1 data |
| req_byte | input | 8 | Byte to write |
| full_width | input | 1 | 1 = eight-line bus, 0 = four-line bus |
| lcd_rs | output | 1 | Display register select |
| lcd_rw | output | 1 | Display read/write, always 0 |
| lcd_e | output | 1 | Display enable strobe |
| lcd_db | output | 8 | Display data lines |

## Verification
Counted from the edge that accepts a request, the first enable rise is due 2 cycles later and each fall 12 cycles after its rise. In half-width mode the second rise comes 25 cycles after the first. Ready returns EXEC cycles after the final fall. The bench sets short and long waits of 100 and 400 cycles so both cases fit the run. A monitor samples on the falling clock edge. It records the negedge index of the acceptance, of every enable transition and of the return of ready, and each scenario task compares those indices with offsets derived from the nanosecond rules.

// File: rtl/lcdw_pkg.sv
package lcdw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HIGH,
        ST_GAP,
        ST_EXEC
    } lcdw_state_e;

    typedef struct packed {
        logic       rs;
        logic [7:0] data;
        logic       full;
        logic       second;
    } lcdw_xfer_s;

    // round a nanosecond interval up to whole clock cycles, never below one
    function automatic int unsigned ns_to_cycles(longint unsigned clk_hz,
                                                 longint unsigned ns);
        longint unsigned c;
        c = (ns * clk_hz + 64'd999_999_999) / 64'd1_000_000_000;
        return (c == 0) ? 1 : int'(c);
    endfunction

    // clear and home style instructions need the long execution time
    function automatic logic is_slow_cmd(logic rs, logic [7:0] data);
        return !rs && (data[7:2] == 6'd0) && (data[1:0] != 2'd0);
    endfunction

endpackage

// File: rtl/lcdw_timer.sv
module lcdw_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/lcdw_bus_lane.sv
module lcdw_bus_lane #(
    parameter int DB_W = 8
) (
    input  logic [DB_W-1:0] data,
    input  logic            full,
    input  logic            second,
    output logic [DB_W-1:0] bus
);
    localparam int NIB = DB_W / 2;

    always_comb begin
        if (full)
            bus = data;
        else if (second)
            bus = {data[NIB-1:0], {NIB{1'b0}}};
        else
            bus = {data[DB_W-1:NIB], {NIB{1'b0}}};
    end
endmodule

// File: rtl/lcd_write_engine.sv
module lcd_write_engine
    import lcdw_pkg::*;
#(
    parameter longint unsigned CLK_HZ    = 50_000_000,
    parameter longint unsigned SETUP_NS  = 40,
    parameter longint unsigned PULSE_NS  = 230,
    parameter longint unsigned HOLD_NS   = 10,
    parameter longint unsigned CYCLE_NS  = 500,
    parameter longint unsigned SHORT_NS  = 40_000,
    parameter longint unsigned LONG_NS   = 1_640_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    output logic       req_ready,
    input  logic       req_rs,
    input  logic [7:0] req_byte,
    input  logic       full_width,
    output logic       lcd_rs,
    output logic       lcd_rw,
    output logic       lcd_e,
    output logic [7:0] lcd_db
);
    localparam int T_AS    = ns_to_cycles(CLK_HZ, SETUP_NS);
    localparam int T_PW    = ns_to_cycles(CLK_HZ, PULSE_NS);
    localparam int T_H     = ns_to_cycles(CLK_HZ, HOLD_NS);
    localparam int T_CYC   = ns_to_cycles(CLK_HZ, CYCLE_NS);
    localparam int T_SHORT = ns_to_cycles(CLK_HZ, SHORT_NS);
    localparam int T_LONG  = ns_to_cycles(CLK_HZ, LONG_NS);
    localparam int GAP_RAW = T_CYC - T_PW - T_AS;
    localparam int T_GAP   = (GAP_RAW > T_H) ? GAP_RAW : T_H;
    localparam int MAXC    = (T_LONG > T_SHORT) ? T_LONG : T_SHORT;
    localparam int CNT_W   = $clog2(MAXC + 1);

    lcdw_state_e  st, st_n;
    lcdw_xfer_s   xfer_q, xfer_n;
    logic         e_q, e_n;
    logic         rs_q, rs_n;
    logic [7:0]   db_q, db_n;
    logic         tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic         tmr_done;
    logic [7:0]   lane_bus;
    lcdw_xfer_s   lane_src;

    lcdw_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    lcdw_bus_lane #(.DB_W(8)) u_lane (
        .data   (lane_src.data),
        .full   (lane_src.full),
        .second (lane_src.second),
        .bus    (lane_bus)
    );

    always_comb begin
        st_n     = st;
        xfer_n   = xfer_q;
        e_n      = e_q;
        rs_n     = rs_q;
        db_n     = db_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        lane_src = xfer_q;
        case (st)
            ST_IDLE: begin
                lane_src = '{rs: req_rs, data: req_byte, full: full_width, second: 1'b0};
                if (req_valid) begin
                    xfer_n   = lane_src;
                    rs_n     = req_rs;
                    db_n     = lane_bus;
                    st_n     = ST_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(T_AS - 1);
                end
            end
            ST_SETUP: if (tmr_done) begin
                e_n      = 1'b1;
                st_n     = ST_HIGH;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(T_PW - 1);
            end
            ST_HIGH: if (tmr_done) begin
                e_n      = 1'b0;
                tmr_load = 1'b1;
                if (!xfer_q.full && !xfer_q.second) begin
                    st_n    = ST_GAP;
                    tmr_val = CNT_W'(T_GAP - 1);
                end else begin
                    st_n    = ST_EXEC;
                    tmr_val = is_slow_cmd(xfer_q.rs, xfer_q.data)
                              ? CNT_W'(T_LONG - 1) : CNT_W'(T_SHORT - 1);
                end
            end
            ST_GAP: begin
                lane_src.second = 1'b1;
                if (tmr_done) begin
                    xfer_n.second = 1'b1;
                    db_n          = lane_bus;
                    st_n          = ST_SETUP;
                    tmr_load      = 1'b1;
                    tmr_val       = CNT_W'(T_AS - 1);
                end
            end
            ST_EXEC: if (tmr_done) st_n = ST_IDLE;
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            xfer_q <= '0;
            e_q    <= 1'b0;
            rs_q   <= 1'b0;
            db_q   <= '0;
        end else begin
            st     <= st_n;
            xfer_q <= xfer_n;
            e_q    <= e_n;
            rs_q   <= rs_n;
            db_q   <= db_n;
        end
    end

    assign req_ready = (st == ST_IDLE);
    assign lcd_e     = e_q;
    assign lcd_rs    = rs_q;
    assign lcd_rw    = 1'b0;
    assign lcd_db    = db_q;
endmodule

// File: rtl/lcdw_checker.sv
module lcdw_checker #(
    parameter int T_PW = 12
) (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_ready,
    input logic       lcd_rs,
    input logic       lcd_rw,
    input logic       lcd_e,
    input logic [7:0] lcd_db,
    input logic       half_mode
);
    logic [15:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst)
            hi_cnt <= '0;
        else if (lcd_e)
            hi_cnt <= hi_cnt + 1'b1;
        else
            hi_cnt <= '0;
    end

    AST_RW_ALWAYS_WRITE: assert property (@(posedge clk) disable iff (rst)
        lcd_rw == 1'b0);                                              // R3
    AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);                     // R2
    AST_BUSY_WHILE_STROBE: assert property (@(posedge clk) disable iff (rst)
        lcd_e |-> !req_ready);                                        // R2
    AST_DB_STABLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        lcd_e |-> $stable(lcd_db));                                   // R7
    AST_RS_STABLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        lcd_e |-> $stable(lcd_rs));                                   // R7
    AST_DB_HELD_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(lcd_e) |-> $stable(lcd_db) && $stable(lcd_rs));         // R7
    AST_LOW_LINES_ZERO: assert property (@(posedge clk) disable iff (rst)
        (lcd_e && half_mode) |-> lcd_db[3:0] == 4'd0);                // R5
    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $fell(lcd_e) |-> hi_cnt >= 16'(T_PW));                        // R6
endmodule

bind lcd_write_engine lcdw_checker #(.T_PW(T_PW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .lcd_rs    (lcd_rs),
    .lcd_rw    (lcd_rw),
    .lcd_e     (lcd_e),
    .lcd_db    (lcd_db),
    .half_mode (!xfer_q.full)
);

// File: tb/tb_lcd_write_engine.sv
module tb_lcd_write_engine;
    // 50 MHz: setup 2, pulse 12, gap 11, cycle 25; short 100, long 400 cycles
    localparam int TAS = 2, TPW = 12, TGAP = 11, TCYC = 25;
    localparam int EXS = 100, EXL = 400;

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 1'b0, req_rs = 1'b0, full_width = 1'b1;
    logic [7:0] req_byte = 8'h00;
    logic req_ready, lcd_rs, lcd_rw, lcd_e;
    logic [7:0] lcd_db;
    int checks = 0, errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    lcd_write_engine #(.SHORT_NS(2000), .LONG_NS(8000)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_rs(req_rs), .req_byte(req_byte), .full_width(full_width),
        .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_e(lcd_e), .lcd_db(lcd_db));

    // negedge monitor
    int ncyc = 0, acc_n = 0, ready_n = 0, npulse = 0;
    int rise_n [4], fall_n [4];
    logic [7:0] db_r [4], db_f [4], db_pre;
    logic rs_r [4];
    bit armed = 0, unstable = 0, rw_bad = 0, prev_e = 0;

    always @(negedge clk) begin
        ncyc++;
        if (req_valid && req_ready) begin
            acc_n = ncyc; npulse = 0; unstable = 0; rw_bad = 0; armed = 1;
        end else if (armed) begin
            if (ncyc == acc_n + 1) db_pre = lcd_db;
            if (lcd_rw) rw_bad = 1;
            if (lcd_e && !prev_e) begin
                rise_n[npulse] = ncyc; db_r[npulse] = lcd_db; rs_r[npulse] = lcd_rs;
            end
            if (lcd_e && prev_e && (lcd_db != db_r[npulse] || lcd_rs != rs_r[npulse]))
                unstable = 1;
            if (!lcd_e && prev_e) begin
                fall_n[npulse] = ncyc; db_f[npulse] = lcd_db;
                if (npulse < 3) npulse++;
            end
            if (req_ready) begin ready_n = ncyc; armed = 0; end
        end
        prev_e = lcd_e;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_xfer(input logic rs, input logic [7:0] b, input logic full,
                            input int exec);
        int np, last_fall;
        logic [7:0] e0, e1;
        @(posedge clk); #2;
        req_valid = 1'b1; req_rs = rs; req_byte = b; full_width = full;
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #2;
        req_valid = 1'b0; full_width = ~full;   // width change after acceptance
        do @(posedge clk); while (armed);
        np = full ? 1 : 2;
        e0 = full ? b : {b[7:4], 4'h0};
        e1 = {b[3:0], 4'h0};
        chk(npulse == np, full ? "R4 pulse count" : "R5 pulse count", npulse, np);
        chk(rise_n[0] - acc_n == TAS + 1, "R7 setup before rise", rise_n[0] - acc_n, TAS + 1);
        chk(db_pre == e0, "R7 data on accepting edge", db_pre, e0);
        chk(fall_n[0] - rise_n[0] == TPW, "R6 pulse width", fall_n[0] - rise_n[0], TPW);
        chk(db_r[0] == e0, full ? "R4 byte on bus" : "R5 high nibble first", db_r[0], e0);
        chk(db_f[0] == e0, "R7 hold after fall", db_f[0], e0);
        chk(rs_r[0] == rs, "R3 register select", rs_r[0], rs);
        chk(!rw_bad && !unstable, "R3/R7 rw low and bus stable", {rw_bad, unstable}, 0);
        last_fall = fall_n[0];
        if (!full) begin
            chk(rise_n[1] - rise_n[0] >= TCYC, "R8 strobe spacing", rise_n[1] - rise_n[0], TCYC);
            chk(rise_n[1] - fall_n[0] == TGAP + TAS, "R8 gap", rise_n[1] - fall_n[0], TGAP + TAS);
            chk(fall_n[1] - rise_n[1] == TPW, "R6 second width", fall_n[1] - rise_n[1], TPW);
            chk(db_r[1] == e1, "R5 low nibble second", db_r[1], e1);
            chk(rs_r[1] == rs, "R3 select second", rs_r[1], rs);
            last_fall = fall_n[1];
        end
        chk(ready_n - last_fall == exec, "R2/R9 execution wait", ready_n - last_fall, exec);
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
        chk(lcd_e == 1'b0 && lcd_rw == 1'b0 && lcd_rs == 1'b0, "R1 controls", {lcd_e, lcd_rw, lcd_rs}, 0);
        chk(lcd_db == 8'h00, "R1 data lines", lcd_db, 0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #2 rst = 1'b0;
        test_reset();
        run_xfer(1'b1, 8'h41, 1'b1, EXS);   // R4 data write
        run_xfer(1'b0, 8'h38, 1'b1, EXS);   // R9 ordinary instruction
        run_xfer(1'b0, 8'h01, 1'b1, EXL);   // R9 clear
        run_xfer(1'b0, 8'h02, 1'b0, EXL);   // R9 home, half width
        run_xfer(1'b0, 8'h03, 1'b1, EXL);   // R9 upper edge of slow set
        run_xfer(1'b0, 8'h04, 1'b1, EXS);   // R9 just outside
        run_xfer(1'b0, 8'h00, 1'b0, EXS);   // R9 zero byte
        run_xfer(1'b1, 8'h01, 1'b1, EXS);   // R9 data 0x01 is short
        run_xfer(1'b1, 8'hA5, 1'b0, EXS);   // R5 nibble order
        run_xfer(1'b1, 8'h5A, 1'b0, EXS);   // R5 second pattern
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual 1 expected 0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule